// File: doc/BRIEF.md
# Nine-level staircase gate generator

This block drives the three legs of a three-phase, nine-level clamped inverter. A 16-bit phase accumulator moves forward by a programmable step on every sample tick. Phase A reads the accumulator directly. Phases B and C read copies that lag by one third and two thirds of full scale. Each phase position is turned into a signed level from -4 to +4. The level comes from comparing the position against four programmable switching angles. The shape has quarter-wave symmetry: it rises through the positive levels, falls back, and then repeats with negative levels in the second half-cycle. Each level is then mapped to a ten-bit gate-enable vector for that leg.

The host writes the angles and the step through a strobe into shadow registers. They are copied into the working set only when phase A passes through zero, so a cycle in progress never sees a mixture of old and new settings. The step sets the output frequency: f = f_tick · step / 65536. The tick rate is picked so that the useful range, for example 20 Hz to 100 Hz, maps onto convenient step values. An enable input holds every gate off.

Top module: `stair9_gate_gen`

## Requirements
- R1: A synchronous reset clears the accumulator, both step registers and all angle registers to zero.
- R2: On a cycle with `tick` high the accumulator becomes (acc + step) mod 65536. When the accumulator is zero at that tick, it becomes the shadow step instead, and the working set is loaded at the same edge. With `tick` low the accumulator holds.
- R3: For a position p whose bit 15 is 0 and bit 14 is 0, the level is +n. Here n is the number of working angles a_k with a_k <= p[13:0]. Angles are 14-bit, so 16384 stands for 90 degrees.
- R4: For a position whose bit 15 is 0 and bit 14 is 1, n is the number of angles with a_k < 16384 - p[13:0]. The level therefore steps down at 180°−a4, 180°−a3, 180°−a2 and 180°−a1.
- R5: When bit 15 is 1, the magnitude is found from bits 14:0 exactly as in R3 and R4, and the level is −n. Levels are reported as 4-bit two's complement.
- R6: Gate bit i is switch Q(i+1). Level +n (n = 1..4) sets bits 0..n−1 and bit 9, and nothing else.
- R7: Level −n sets bits 4..3+n and bit 8, and nothing else. Level 0 sets no bit.
- R8: Phase B uses position acc − 21845 and phase C uses acc − 43690, both mod 65536.
- R9: A write with `wr_sel` 0..3 stores angle a1..a4 from `wr_data[13:0]`. Code 4 stores the step. Codes 5..7 change nothing. Stored values reach the outputs only at a tick where acc is zero or where acc + step carries out of 16 bits.
- R10: While `en` is low, all three level codes and all thirty gate bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Output enable; low forces gates off |
| tick | input | 1 | Sample tick that advances the phase |
| wr | input | 1 | Configuration write strobe |
| wr_sel | input | 3 | Target of the write: 0..3 angles, 4 step |
| wr_data | input | 16 | Write data |
| lvl_a | output | 4 | Phase A level, two's complement |
| lvl_b | output | 4 | Phase B level, two's complement |
| lvl_c | output | 4 | Phase C level, two's complement |
| gate_a | output | 10 | Phase A gate enables, bit i = Q(i+1) |
| gate_b | output | 10 | Phase B gate enables |
| gate_c | output | 10 | Phase C gate enables |

## Verification
Levels and gates are combinational functions of registered state. They therefore change only at the rising edge that consumes a tick, reset or write, and they are final within that same cycle. The bench drives each input on the falling edge and applies its model update at the rising edge. It compares all three phases 1 ns after every rising edge, so each result is checked in the first cycle it is due. A write can only be seen after the first later tick where the accumulator sits at zero or wraps through it. The bench counts that edge itself and expects the old shape up to it.

// File: rtl/stair9_gate_gen.sv
`timescale 1ns/1ps
module stair9_gate_gen #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          wr,
  input  logic [2:0]    wr_sel,
  input  logic [PW-1:0] wr_data,
  output logic [3:0]    lvl_a,
  output logic [3:0]    lvl_b,
  output logic [3:0]    lvl_c,
  output logic [9:0]    gate_a,
  output logic [9:0]    gate_b,
  output logic [9:0]    gate_c
);
  localparam int AW = PW - 2;
  localparam int THIRD_I = (2**PW + 1) / 3;
  localparam logic [PW-1:0] OFS_B = PW'(THIRD_I);
  localparam logic [PW-1:0] OFS_C = PW'(2 * THIRD_I);

  logic [PW-1:0]   acc, inc_sh, inc_act;
  logic [4*AW-1:0] ang_sh, ang_act;
  logic [PW:0]     sum;
  logic            acc_zero, load;

  assign sum      = {1'b0, acc} + {1'b0, inc_act};
  assign acc_zero = (acc == '0);
  assign load     = tick && (acc_zero || sum[PW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      inc_sh  <= '0;
      inc_act <= '0;
      ang_sh  <= '0;
      ang_act <= '0;
    end else begin
      if (load) begin
        inc_act <= inc_sh;
        ang_act <= ang_sh;
      end
      if (tick)
        acc <= acc_zero ? inc_sh : sum[PW-1:0];
      if (wr) begin
        if (wr_sel == 3'd4)
          inc_sh <= wr_data;
        else if (wr_sel < 3'd4)
          ang_sh[wr_sel[1:0]*AW +: AW] <= wr_data[AW-1:0];
      end
    end
  end

  function automatic logic [3:0] level_of(input logic [PW-1:0] p, input logic [4*AW-1:0] av);
    logic [AW-1:0] m;
    logic [2:0]    n;
    m = p[PW-2] ? ~p[AW-1:0] : p[AW-1:0];
    n = '0;
    for (int k = 0; k < 4; k++)
      if (av[k*AW +: AW] <= m) n = n + 3'd1;
    return p[PW-1] ? (4'd0 - {1'b0, n}) : {1'b0, n};
  endfunction

  function automatic logic [9:0] gates_of(input logic [3:0] l);
    logic [9:0] g;
    logic [3:0] mag;
    g   = '0;
    mag = l[3] ? (4'd0 - l) : l;
    if (l != 4'd0) begin
      if (l[3]) g[8] = 1'b1;
      else      g[9] = 1'b1;
      for (int i = 0; i < 4; i++)
        if (4'(i) < mag) g[l[3] ? 4 + i : i] = 1'b1;
    end
    return g;
  endfunction

  logic [3:0] la, lb, lc;
  assign la = level_of(acc, ang_act);
  assign lb = level_of(acc - OFS_B, ang_act);
  assign lc = level_of(acc - OFS_C, ang_act);

  assign lvl_a  = en ? la : 4'd0;
  assign lvl_b  = en ? lb : 4'd0;
  assign lvl_c  = en ? lc : 4'd0;
  assign gate_a = gates_of(lvl_a);
  assign gate_b = gates_of(lvl_b);
  assign gate_c = gates_of(lvl_c);

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (acc == '0 && inc_act == '0));
  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(acc));
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(inc_act) && $stable(ang_act)));
  assert_rail_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gate_a[9], gate_a[8]}) && !((|gate_a[3:0]) && (|gate_a[7:4])));
  assert_zero_level_off_R7: assert property (@(posedge clk) disable iff (rst)
    (lvl_b == 4'd0) |-> (gate_b == 10'd0));
  assert_disabled_off_R10: assert property (@(posedge clk) disable iff (rst)
    !en |-> (gate_a == '0 && gate_b == '0 && gate_c == '0));
endmodule

// File: tb/sim_stair9_gate_gen.sv
`timescale 1ns/1ps
module sim_stair9_gate_gen;
  logic clk = 1'b0;
  logic rst, en, tick, wr;
  logic [2:0] wr_sel;
  logic [15:0] wr_data;
  logic [3:0] lvl_a, lvl_b, lvl_c;
  logic [9:0] gate_a, gate_b, gate_c;

  int checks = 0, errors = 0;
  int acc_m = 0, inc_act = 0, inc_sh = 0;
  int ang_act[4], ang_sh[4];
  bit done = 0;

  always #10 clk = ~clk;

  stair9_gate_gen u0 (.clk(clk), .rst(rst), .en(en), .tick(tick), .wr(wr),
    .wr_sel(wr_sel), .wr_data(wr_data), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
    .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c));

  function automatic int exp_lvl(int p);
    int pos, n;
    pos = p % 32768;
    n = 0;
    for (int k = 0; k < 4; k++) begin
      if (pos < 16384) begin
        if (ang_act[k] <= pos) n++;
      end else begin
        if (ang_act[k] < 32768 - pos) n++;
      end
    end
    return (p >= 32768) ? -n : n;
  endfunction

  function automatic logic [9:0] exp_gate(int l);
    logic [9:0] g = '0;
    if (l > 0) begin
      g[9] = 1'b1;
      for (int i = 0; i < l; i++) g[i] = 1'b1;
    end else if (l < 0) begin
      g[8] = 1'b1;
      for (int i = 0; i < -l; i++) g[4+i] = 1'b1;
    end
    return g;
  endfunction

  task automatic check_phase(int ph, logic [3:0] lv, logic [9:0] gv, string ctx);
    int p, el, al;
    string tq;
    logic [9:0] eg;
    p  = (acc_m - ph * 21845 + 65536) % 65536;
    el = en ? exp_lvl(p) : 0;
    eg = exp_gate(el);
    al = $signed(lv);
    if (!en) tq = "R10";
    else if (ph != 0) tq = "R8";
    else if (p >= 32768) tq = "R5";
    else if (p >= 16384) tq = "R4";
    else tq = "R3";
    checks++;
    if (al != el) begin
      errors++;
      $display("FAIL %s (%s) phase %0d pos %0d: level act %0d exp %0d", tq, ctx, ph, p, al, el);
    end
    checks++;
    if (gv !== eg) begin
      errors++;
      $display("FAIL %s (%s) phase %0d level %0d: gates act %b exp %b",
               (el < 1) ? "R7" : "R6", ctx, ph, el, gv, eg);
    end
  endtask

  task automatic check_all(string ctx);
    check_phase(0, lvl_a, gate_a, ctx);
    check_phase(1, lvl_b, gate_b, ctx);
    check_phase(2, lvl_c, gate_c, ctx);
  endtask

  task automatic step(bit t, bit w, int sel, int data, string ctx);
    int s;
    @(negedge clk);
    tick = t; wr = w; wr_sel = 3'(sel); wr_data = 16'(data);
    @(posedge clk);
    if (t) begin
      if (acc_m == 0) begin
        inc_act = inc_sh; ang_act = ang_sh; acc_m = inc_sh;
      end else begin
        s = acc_m + inc_act;
        if (s >= 65536) begin inc_act = inc_sh; ang_act = ang_sh; end
        acc_m = s % 65536;
      end
    end
    if (w) begin
      if (sel == 4) inc_sh = data;
      else if (sel < 4) ang_sh[sel] = data % 16384;
    end
    #1;
    check_all(ctx);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin ang_act[k] = 0; ang_sh[k] = 0; end
    rst = 1; en = 0; tick = 0; wr = 0; wr_sel = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset, disabled");
    @(negedge clk); rst = 0; en = 1;
    @(posedge clk); #1;
    check_all("R1 reset state enabled");

    // R9: writes land in shadow; first tick at zero loads them
    step(0, 1, 0, 1600, "R9 write a1");
    step(0, 1, 1, 4800, "R9 write a2");
    step(0, 1, 2, 8000, "R9 write a3");
    step(0, 1, 3, 12800, "R9 write a4");
    step(0, 1, 4, 16, "R9 write step");
    // R3 R4 R5: step 16 lands exactly on every angle and mirror point
    for (int i = 0; i < 4200; i++) step(1, 0, 0, 0, "sweep step16");
    // R2: no tick, accumulator holds
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R2 hold");
    // R9: mid-cycle rewrite, old shape must remain until wrap; code 5 ignored
    step(0, 1, 0, 100, "R9 new a1");
    step(0, 1, 1, 3000, "R9 new a2");
    step(0, 1, 2, 9000, "R9 new a3");
    step(0, 1, 3, 16383, "R9 new a4 max");
    step(0, 1, 4, 97, "R9 new step");
    step(0, 1, 5, 7, "R9 ignored code");
    for (int i = 0; i < 4300; i++) step(1, 0, 0, 0, "R9 switchover");
    // R2: sparse ticks
    for (int i = 0; i < 1500; i++) step((i % 3) == 0, 0, 0, 0, "R2 sparse tick");
    // R10: disable mid-run, then resume
    en = 0;
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, "R10 disabled");
    en = 1;
    for (int i = 0; i < 800; i++) step(1, 0, 0, 0, "R10 resumed");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule